// File: doc/BRIEF.md
# Error-Location Result and Interrupt Aggregator

This block is the software-facing front end of an error-location engine that serves eight independent syndrome channels. Software arms a channel by setting that channel's syndrome-ready bit, and the block issues the channel to the engine with a one-cycle start pulse. When the engine finishes a channel, it returns a completion beat. The beat carries a correctable flag, an error count and sixteen candidate bit addresses. The block captures these into per-channel result registers and raises a per-channel status bit. The block also gathers completions into a page-level status bit and drives one level interrupt that is filtered through an enable register.

The block supports two modes. In continuous mode the page-selection register is all zeros, and each channel reports only on its own. In page mode the page-selection register names a set of channels. The page status bit is raised only after every channel in that set has completed since the last page clear or the last rewrite of the selection. The engine's algebra is not part of this block. Its port behaviour is only the start vector and the completion beat.

The register bus uses word addresses and is read combinationally. The map is: status at 0x00, enable at 0x01, configuration at 0x02, page selection at 0x03, syndrome-ready word of channel c at 0x10+c, result word of channel c at 0x20+c, and location k of channel c at 0x40+16·c+k. Unmapped addresses read as zero.

Top module: `locator_status_hub`

## Requirements
- R1: After reset, the status, enable, page-selection, configuration and all result and location registers read 0, `irq` is 0 and `eng_start` is 0.
- R2: A write with bit 16 = 1 to channel c's syndrome-ready word (0x10+c) while that bit reads 0 sets the bit and drives `eng_start[c]` high for exactly the next cycle. A write of 1 while the bit is already 1 gives no pulse. A write of 0 clears the bit. The bit reads back at bit 16.
- R3: A completion beat (`done_valid`, `done_chan` = c) for a channel whose ready bit is 1 has four effects in one clock edge. It stores the correctable flag at bit 8 of result word 0x20+c. It stores the 5-bit count at bits 4:0 of that word. It clears the ready bit and sets status bit c. If the channel's ready bit is 0, the beat changes nothing. If a ready-bit write and an accepted completion of the same channel fall in one cycle, the completion wins and no start pulse is given.
- R4: Location k of a channel (bits 12:0 of 0x40+16·c+k) holds the returned address for k < count. It reads 0 for k ≥ count. A count above 16 keeps all sixteen addresses.
- R5: Status (0x00, channel bits 7:0, page bit 8) is write-one-to-clear, and a 0 in the write data leaves a bit unchanged. A bit set by hardware in the same cycle as a clear of it stays 1.
- R6: `irq` is 1 exactly when some status bit and the enable bit at the same position (0x01, bits 8:0) are both 1.
- R7: With page selection (0x03, bits 7:0) non-zero, status bit 8 is set at the edge that completes the last selected channel that had not yet completed.
- R8: With page selection all zero, status bit 8 is never set by completions.
- R9: Completed-channel tracking for the page restarts when software writes 1 to status bit 8 or writes the page-selection register. Channels that completed earlier must complete again before the page bit is set.
- R10: The configuration register (0x02) keeps an 11-bit size at bits 26:16 and a 2-bit level at bits 1:0. All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| eng_start | output | 8 | One-cycle start pulse per channel to the engine |
| done_valid | input | 1 | Completion beat from the engine |
| done_chan | input | 3 | Channel of the completion |
| done_corr | input | 1 | Correctable exit flag |
| done_cnt | input | 5 | Number of errors located |
| done_locs | input | 208 | Sixteen 13-bit bit addresses, location k at bits 13k+12:13k |
| irq | output | 1 | Masked interrupt line |

## Verification
The in-RTL assertions check, on every cycle, several rules that hold at all times. A start pulse appears only on a ready-bit rising edge, and at most one channel starts at a time. An accepted completion always clears the ready bit. Locations past the count stay zero. A hardware set survives a simultaneous clear. An empty page selection never raises the page bit. The tracking vector empties after a page clear or a selection rewrite. Other behaviour can only be shown by the bench's scenarios, which compare the whole register view against a reference model. This covers the exact register contents after mixed random traffic, a page spanning a chosen subset of channels, completions for idle channels that are ignored, and the read-back layout of every field.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  localparam int NCH      = 8;
  localparam int NLOC     = 16;
  localparam int LOCW     = 13;
  localparam int CNTW     = 5;
  localparam int AW       = 8;
  localparam int DW       = 32;
  localparam int CHW      = $clog2(NCH);
  localparam int SIZEW    = 11;
  localparam int SIZE_LSB = 16;
  localparam int LVLW     = 2;
  localparam int VLD_BIT  = 16;
  localparam int CORR_BIT = 8;

  localparam logic [AW-1:0] A_STAT = 8'h00;
  localparam logic [AW-1:0] A_EN   = 8'h01;
  localparam logic [AW-1:0] A_CFG  = 8'h02;
  localparam logic [AW-1:0] A_PAGE = 8'h03;
  localparam logic [AW-1:0] A_SYN  = 8'h10;
  localparam logic [AW-1:0] A_RES  = 8'h20;
  localparam logic [AW-1:0] A_LOC  = 8'h40;

  // keep a returned location only when its index is inside the reported count
  function automatic logic [LOCW-1:0] loc_keep(input logic [LOCW-1:0] raw,
                                                input int unsigned idx,
                                                input logic [CNTW-1:0] cnt);
    return (idx < int'(cnt)) ? raw : '0;
  endfunction

  // page complete: selection non-empty and every selected channel done
  function automatic logic page_full(input logic [NCH-1:0] sel,
                                     input logic [NCH-1:0] done);
    return (sel != '0) && ((done & sel) == sel);
  endfunction
endpackage

// File: rtl/lsh_chan.sv
module lsh_chan
  import lsh_pkg::*;
#(
  parameter int P_NLOC = NLOC,
  parameter int P_LOCW = LOCW,
  parameter int P_CNTW = CNTW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     syn_wr,
  input  logic                     syn_wval,
  input  logic                     done_hit,
  input  logic                     done_corr,
  input  logic [P_CNTW-1:0]        done_cnt,
  input  logic [P_NLOC*P_LOCW-1:0] done_locs,
  output logic                     busy,
  output logic                     start,
  output logic                     done_acc,
  output logic                     res_corr,
  output logic [P_CNTW-1:0]        res_cnt,
  output logic [P_NLOC*P_LOCW-1:0] res_locs
);
  // completion only counts for a channel that was issued
  assign done_acc = done_hit & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      start    <= 1'b0;
      res_corr <= 1'b0;
      res_cnt  <= '0;
    end else begin
      start <= syn_wr & syn_wval & ~busy & ~done_acc;
      if (done_acc)    busy <= 1'b0;
      else if (syn_wr) busy <= syn_wval;
      if (done_acc) begin
        res_corr <= done_corr;
        res_cnt  <= done_cnt;
      end
    end
  end

  for (genvar k = 0; k < P_NLOC; k++) begin : g_loc
    always_ff @(posedge clk) begin
      if (!rst_n)
        res_locs[k*P_LOCW +: P_LOCW] <= '0;
      else if (done_acc)
        res_locs[k*P_LOCW +: P_LOCW] <= loc_keep(done_locs[k*P_LOCW +: P_LOCW], k, done_cnt);
    end

    a_r4_loc_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(res_cnt) <= k) |-> (res_locs[k*P_LOCW +: P_LOCW] == '0));
  end

  a_r2_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (busy && !$past(busy)));

  a_r3_acc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> !busy);
endmodule

// File: rtl/lsh_page.sv
module lsh_page
  import lsh_pkg::*;
#(
  parameter int P_NCH = NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [P_NCH-1:0] sel,
  input  logic             sel_wr,
  input  logic             page_clr,
  input  logic [P_NCH-1:0] acc_vec,
  output logic             page_set,
  output logic [P_NCH-1:0] done_vec
);
  logic [P_NCH-1:0] done_nxt;

  always_comb begin
    done_nxt = ((sel_wr || page_clr) ? '0 : done_vec) | acc_vec;
    page_set = page_full(sel, done_nxt) && !sel_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done_vec <= '0;
    else        done_vec <= done_nxt;
  end

  a_r8_empty_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> !page_set);

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_wr || page_clr) && acc_vec == '0) |=> (done_vec == '0));
endmodule

// File: rtl/lsh_stat.sv
module lsh_stat
  import lsh_pkg::*;
#(
  parameter int P_NST = NCH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [P_NST-1:0] set_vec,
  input  logic             clr_wr,
  input  logic [P_NST-1:0] clr_mask,
  input  logic [P_NST-1:0] en,
  output logic [P_NST-1:0] stat,
  output logic             irq
);
  logic [P_NST-1:0] clr_eff;
  assign clr_eff = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_eff) | set_vec;
  end

  assign irq = |(stat & en);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat & $past(set_vec)) == $past(set_vec)));

  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && set_vec == '0) |=> ((stat & $past(clr_mask)) == '0));

  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

// File: rtl/locator_status_hub.sv
module locator_status_hub
  import lsh_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic [NCH-1:0]       eng_start,
  input  logic                 done_valid,
  input  logic [CHW-1:0]       done_chan,
  input  logic                 done_corr,
  input  logic [CNTW-1:0]      done_cnt,
  input  logic [NLOC*LOCW-1:0] done_locs,
  output logic                 irq
);
  localparam int NST = NCH + 1;

  logic [NST-1:0]   en_q;
  logic [NCH-1:0]   sel_q;
  logic [SIZEW-1:0] cfg_size;
  logic [LVLW-1:0]  cfg_lvl;

  logic [NCH-1:0]   busy, acc_vec, syn_wr, done_hit, res_corr;
  logic [NCH-1:0][CNTW-1:0]      res_cnt;
  logic [NCH-1:0][NLOC*LOCW-1:0] res_locs;
  logic [NST-1:0]   stat;
  logic [NCH-1:0]   done_vec;
  logic             page_set, sel_wr, stat_wr, en_wr, cfg_wr;

  assign sel_wr  = reg_we && reg_addr == A_PAGE;
  assign stat_wr = reg_we && reg_addr == A_STAT;
  assign en_wr   = reg_we && reg_addr == A_EN;
  assign cfg_wr  = reg_we && reg_addr == A_CFG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      sel_q    <= '0;
      cfg_size <= '0;
      cfg_lvl  <= '0;
    end else begin
      if (en_wr)  en_q  <= reg_wdata[NST-1:0];
      if (sel_wr) sel_q <= reg_wdata[NCH-1:0];
      if (cfg_wr) begin
        cfg_size <= reg_wdata[SIZE_LSB +: SIZEW];
        cfg_lvl  <= reg_wdata[LVLW-1:0];
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign syn_wr[c]   = reg_we && reg_addr == AW'(int'(A_SYN) + c);
    assign done_hit[c] = done_valid && done_chan == CHW'(c);

    lsh_chan #(.P_NLOC(NLOC), .P_LOCW(LOCW), .P_CNTW(CNTW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .syn_wr    (syn_wr[c]),
      .syn_wval  (reg_wdata[VLD_BIT]),
      .done_hit  (done_hit[c]),
      .done_corr (done_corr),
      .done_cnt  (done_cnt),
      .done_locs (done_locs),
      .busy      (busy[c]),
      .start     (eng_start[c]),
      .done_acc  (acc_vec[c]),
      .res_corr  (res_corr[c]),
      .res_cnt   (res_cnt[c]),
      .res_locs  (res_locs[c])
    );
  end

  lsh_page #(.P_NCH(NCH)) u_page (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel_q),
    .sel_wr   (sel_wr),
    .page_clr (stat_wr && reg_wdata[NCH]),
    .acc_vec  (acc_vec),
    .page_set (page_set),
    .done_vec (done_vec)
  );

  lsh_stat #(.P_NST(NST)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  ({page_set, acc_vec}),
    .clr_wr   (stat_wr),
    .clr_mask (reg_wdata[NST-1:0]),
    .en       (en_q),
    .stat     (stat),
    .irq      (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_STAT) reg_rdata[NST-1:0] = stat;
    if (reg_addr == A_EN)   reg_rdata[NST-1:0] = en_q;
    if (reg_addr == A_PAGE) reg_rdata[NCH-1:0] = sel_q;
    if (reg_addr == A_CFG) begin
      reg_rdata[SIZE_LSB +: SIZEW] = cfg_size;
      reg_rdata[LVLW-1:0]          = cfg_lvl;
    end
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == AW'(int'(A_SYN) + c)) reg_rdata[VLD_BIT] = busy[c];
      if (reg_addr == AW'(int'(A_RES) + c)) begin
        reg_rdata[CORR_BIT]  = res_corr[c];
        reg_rdata[CNTW-1:0]  = res_cnt[c];
      end
      for (int k = 0; k < NLOC; k++)
        if (reg_addr == AW'(int'(A_LOC) + c*NLOC + k))
          reg_rdata[LOCW-1:0] = res_locs[c][k*LOCW +: LOCW];
    end
  end

  a_r2_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_start));

  a_r7_page_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[NCH]) |-> $past(sel_q != '0));
endmodule

// File: tb/locator_status_hub_tb_top.sv
module locator_status_hub_tb_top;
  import lsh_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, reg_we = 1'b0, done_valid = 1'b0, done_corr = 1'b0, irq;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] eng_start;
  logic [CHW-1:0] done_chan = '0;
  logic [CNTW-1:0] done_cnt = '0;
  logic [NLOC*LOCW-1:0] done_locs = '0;

  locator_status_hub dut_i (.*);

  int n_tests = 0, n_fail = 0;

  logic            m_busy [NCH];
  logic            m_corr [NCH];
  logic [CNTW-1:0] m_cnt  [NCH];
  logic [LOCW-1:0] m_loc  [NCH][NLOC];
  logic [NCH:0]    m_stat, m_en;
  logic [NCH-1:0]  m_sel, m_done;
  logic [DW-1:0]   m_cfg;

  function automatic logic all_sel_done(input logic [NCH-1:0] s, input logic [NCH-1:0] d);
    logic any = 1'b0, ok = 1'b1;
    for (int b = 0; b < NCH; b++) if (s[b]) begin any = 1'b1; if (!d[b]) ok = 1'b0; end
    return any && ok;
  endfunction

  function automatic logic want_irq(input logic [NCH:0] s, input logic [NCH:0] e);
    for (int b = 0; b <= NCH; b++) if (s[b] && e[b]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // one bus/engine cycle with model update and start-pulse check
  task automatic step(input bit dw, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit dc, input int ch, input bit corr, input logic [CNTW-1:0] cnt,
                      input logic [NLOC*LOCW-1:0] locs);
    logic [NCH-1:0] exp_start = '0;
    logic acc, pw, pclr;
    acc  = dc && m_busy[ch];
    pw   = dw && a == A_PAGE;
    pclr = dw && a == A_STAT && d[NCH];
    if (dw && a >= A_SYN && a < A_SYN + NCH) begin
      int c = int'(a - A_SYN);
      if (!(acc && c == ch)) begin
        if (d[VLD_BIT] && !m_busy[c]) exp_start[c] = 1'b1;
        m_busy[c] = d[VLD_BIT];
      end
    end
    if (dw && a == A_STAT) m_stat = m_stat & ~d[NCH:0];
    if (acc) begin
      m_busy[ch] = 1'b0; m_corr[ch] = corr; m_cnt[ch] = cnt; m_stat[ch] = 1'b1;
      for (int k = 0; k < NLOC; k++) m_loc[ch][k] = (k < cnt) ? locs[k*LOCW +: LOCW] : '0;
    end
    m_done = ((pw || pclr) ? '0 : m_done) | (acc ? NCH'(1 << ch) : '0);
    if (!pw && all_sel_done(m_sel, m_done)) m_stat[NCH] = 1'b1;
    if (pw) m_sel = d[NCH-1:0];
    if (dw && a == A_EN) m_en = d[NCH:0];
    if (dw && a == A_CFG) m_cfg = d & 32'h07FF_0003;

    @(negedge clk);
    reg_we = dw; reg_addr = a; reg_wdata = d;
    done_valid = dc; done_chan = CHW'(ch); done_corr = corr; done_cnt = cnt; done_locs = locs;
    @(posedge clk); #1;
    reg_we = 1'b0; done_valid = 1'b0;
    chk("R2", "eng_start", DW'(eng_start), DW'(exp_start));
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(1'b1, a, d, 1'b0, 0, 1'b0, '0, '0);
  endtask

  task automatic fin(input int ch, input bit corr, input logic [CNTW-1:0] cnt, input logic [NLOC*LOCW-1:0] locs);
    step(1'b0, '0, '0, 1'b1, ch, corr, cnt, locs);
  endtask

  task automatic check_view(input bit locs_too);
    logic [DW-1:0] v;
    rd(A_STAT, v); chk("R5", "status", v, DW'(m_stat));
    chk("R6", "irq", DW'(irq), DW'(want_irq(m_stat, m_en)));
    rd(A_CFG, v); chk("R10", "config", v, m_cfg);
    for (int c = 0; c < NCH; c++) begin
      rd(A_SYN + AW'(c), v); chk("R2", "ready bit", v, DW'(m_busy[c]) << VLD_BIT);
      rd(A_RES + AW'(c), v); chk("R3", "result", v, (DW'(m_corr[c]) << CORR_BIT) | DW'(m_cnt[c]));
      if (locs_too)
        for (int k = 0; k < NLOC; k++) begin
          rd(A_LOC + AW'(c*NLOC + k), v); chk("R4", "location", v, DW'(m_loc[c][k]));
        end
    end
  endtask

  function automatic logic [NLOC*LOCW-1:0] rand_locs();
    logic [NLOC*LOCW-1:0] r;
    for (int k = 0; k < NLOC; k++) r[k*LOCW +: LOCW] = LOCW'($urandom);
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < NCH; c++) begin
      m_busy[c] = 0; m_corr[c] = 0; m_cnt[c] = '0;
      for (int k = 0; k < NLOC; k++) m_loc[c][k] = '0;
    end
    m_stat = '0; m_en = '0; m_sel = '0; m_done = '0; m_cfg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    check_view(1'b1);
    rd(A_EN, v);   chk("R1", "enable", v, '0);
    rd(A_PAGE, v); chk("R1", "page sel", v, '0);
    chk("R1", "eng_start", DW'(eng_start), '0);

    // R10 config field layout
    wr(A_CFG, 32'hFFFF_FFFF); check_view(1'b0);
    wr(A_CFG, 32'h0123_4562); check_view(1'b0);

    // R2 start, repeat write without pulse, R3 idle completion ignored
    wr(A_SYN + 8'd3, 32'h0001_0000);
    wr(A_SYN + 8'd3, 32'h0001_0000);
    fin(5, 1'b1, 5'd4, rand_locs()); check_view(1'b0);
    // R4 short count, then count above 16
    fin(3, 1'b1, 5'd3, rand_locs()); check_view(1'b1);
    wr(A_SYN + 8'd3, 32'h0001_0000);
    fin(3, 1'b0, 5'd20, rand_locs()); check_view(1'b1);

    // R6 irq through enable, R5 clear
    wr(A_EN, 32'h0000_0008); check_view(1'b0);
    wr(A_STAT, 32'h0000_0000); check_view(1'b0);
    wr(A_STAT, 32'h0000_0008); check_view(1'b0);

    // R5 set wins over clear in same cycle
    wr(A_SYN + 8'd1, 32'h0001_0000);
    step(1'b1, A_STAT, 32'h0000_01FF, 1'b1, 1, 1'b1, 5'd2, rand_locs()); check_view(1'b0);
    // R3 ready write and completion on same channel together
    wr(A_SYN + 8'd6, 32'h0001_0000);
    step(1'b1, A_SYN + 8'd6, 32'h0001_0000, 1'b1, 6, 1'b0, 5'd1, rand_locs()); check_view(1'b0);

    // R7 page over channels 0 and 2
    wr(A_STAT, 32'h0000_01FF);
    wr(A_PAGE, 32'h0000_0005); wr(A_EN, 32'h0000_0100);
    wr(A_SYN + 8'd0, 32'h0001_0000); wr(A_SYN + 8'd2, 32'h0001_0000);
    fin(0, 1'b1, 5'd1, rand_locs()); check_view(1'b0);
    fin(2, 1'b1, 5'd1, rand_locs()); check_view(1'b0);

    // R9 restart after selection rewrite
    wr(A_STAT, 32'h0000_0100);
    wr(A_PAGE, 32'h0000_0003);
    wr(A_SYN + 8'd0, 32'h0001_0000); fin(0, 1'b0, 5'd0, '0);
    wr(A_PAGE, 32'h0000_0003);
    wr(A_SYN + 8'd1, 32'h0001_0000); fin(1, 1'b0, 5'd0, '0); check_view(1'b0);
    wr(A_SYN + 8'd0, 32'h0001_0000); fin(0, 1'b0, 5'd0, '0); check_view(1'b0);

    // R8 continuous mode: never a page bit
    wr(A_PAGE, 32'h0); wr(A_STAT, 32'h0000_01FF);
    for (int c = 0; c < NCH; c++) begin
      wr(A_SYN + AW'(c), 32'h0001_0000); fin(c, 1'b1, 5'd2, rand_locs());
    end
    check_view(1'b0);

    // constrained random traffic
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      int c  = $urandom_range(0, NCH-1);
      case (op)
        0, 1, 2: wr(A_SYN + AW'(c), ($urandom_range(0, 5) != 0) ? 32'h0001_0000 : 32'h0);
        3, 4, 5: fin(c, 1'($urandom), CNTW'($urandom_range(0, 20)), rand_locs());
        6:       wr(A_STAT, DW'($urandom) & 32'h1FF);
        7:       wr(A_EN, DW'($urandom) & 32'h1FF);
        8:       if ($urandom_range(0, 2) == 0) wr(A_PAGE, DW'($urandom) & 32'hFF);
        default: step(1'b1, A_STAT, DW'($urandom) & 32'h1FF, 1'b1, c, 1'($urandom),
                      CNTW'($urandom_range(0, 16)), rand_locs());
      endcase
      check_view(i % 50 == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule